// File: doc/BRIEF.md
# Sign-bit terminated pulse divider

The block turns a fast system clock into a slow periodic event. It does not make a new clock. It emits a single-cycle tick every `DIV_N` enabled clock cycles. With the default `DIV_N = 2229` and a 98.304 MHz input, this gives a tick rate of about 44.1 kHz. A second output, the strobe, shows one bit of the internal count. It marks a wide, fixed part of each period and suits logic that wants a level rather than a pulse.

The count runs downwards from `DIV_N-2`. When the count drops below zero, its top bit (the sign bit) goes high. That bit is the terminal condition, and it is also the tick, so the count path has no comparator. On the next enabled clock after the sign bit rises, the counter reloads `DIV_N-2`. A synchronous reset loads the same value. A low enable freezes the counter and suppresses the tick.

Elaboration stops if any of these hold:
- `DIV_N` is below 2.
- `DIV_N-2` does not fit in the positive half of the counter width.
- The strobe bit is not below the sign bit.

Top module: `pulse_divider`

## Requirements
- R1: `rst` is synchronous and active high. During reset and in the first cycle after it, `tick_o` is 0. The first tick is high in the cycle that follows the (`DIV_N`-1)th enabled clock edge after release. A reset in the middle of a period restarts this timing.
- R2: With the enable held high, consecutive ticks are exactly `DIV_N` clocks apart (2229 by default). With a gated enable, they are exactly `DIV_N` enabled edges apart.
- R3: `tick_o` is never high for two cycles in a row. It is high only while the count is all ones, i.e. while the count is -1 in two's complement.
- R4: While `en` is 0, `tick_o` is 0 and the count keeps its value. When `en` returns to 1, the sequence continues from the held position. This includes a tick that was held back when enable dropped in the terminal cycle.
- R5: `strobe_o` is bit `STROBE_BIT` (default 11) of the 13-bit count. With the defaults, the strobe behaves as follows in each period:
  - it falls 181 clocks after a tick;
  - it then stays low for 2048 clocks;
  - it is high for the other 181 clocks, one of which is the tick cycle.
- R6: While the count is non-negative, each enabled edge lowers it by one. The enabled edge taken in the terminal state loads `DIV_N-2`. A non-negative count never exceeds `DIV_N-2`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock being divided |
| rst | input | 1 | Synchronous active-high reset; loads the start count |
| en | input | 1 | Count enable; when low, the count holds and the tick is masked |
| tick_o | output | 1 | One-cycle pulse per divided period |
| strobe_o | output | 1 | Selected count bit; a wide per-period level |

## Verification
The bound checker watches the count on every cycle:
- it confirms single-step decrements, the reload after the terminal state and the upper bound on non-negative values;
- it confirms the freeze under a low enable and the masking of the tick;
- its own counter of enabled edges checks the spacing between ticks against `DIV_N`, and `DIV_N-1` for the first tick.

The strobe's position and length within the period are visible only at the ports, so the bench measures them. The bench also covers two other cases:
- re-arming of a tick that was held back by a low enable;
- restart timing after a reset in the middle of a period, compared against a cycle model driven by irregular enable patterns.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;

    // Number of bits needed so that (n-2) is a non-negative two's complement value.
    function automatic int unsigned pdiv_span_bits(input int unsigned n);
        return $clog2(n - 1) + 1;
    endfunction

    // Meaning of the counter's top bit.
    typedef enum logic {
        PDIV_COUNTING = 1'b0,
        PDIV_TERMINAL = 1'b1
    } pdiv_phase_e;

endpackage

// File: rtl/pdiv_counter.sv
module pdiv_counter
    import pdiv_pkg::*;
#(
    parameter int unsigned DIV_N = 2229,
    parameter int unsigned CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    output logic [CNT_W-1:0] cnt_o
);

    localparam int unsigned     SIGN   = CNT_W - 1;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(DIV_N - 2);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t  st_d;
    cnt_state_t  st_q;
    pdiv_phase_e phase;

    generate
        if (DIV_N < 2 || pdiv_span_bits(DIV_N) > CNT_W) begin : g_bad_range
            $error("pdiv_counter: DIV_N-2 does not fit the positive range of CNT_W bits");
        end
    endgenerate

    // Next-state logic: the sign bit alone decides between reload and decrement.
    always_comb begin
        phase = pdiv_phase_e'(st_q.cnt[SIGN]);
        st_d  = st_q;
        if (rst) begin
            st_d.cnt = RELOAD;
        end else if (en) begin
            if (phase == PDIV_TERMINAL) begin
                st_d.cnt = RELOAD;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

endmodule

// File: rtl/pdiv_outstage.sv
module pdiv_outstage (
    input  logic term_i,
    input  logic tap_i,
    input  logic en_i,
    output logic tick_o,
    output logic strobe_o
);

    // The tick is the raw sign bit, masked while counting is paused.
    always_comb begin
        tick_o   = term_i & en_i;
        strobe_o = tap_i;
    end

endmodule

// File: rtl/pulse_divider.sv
module pulse_divider #(
    parameter int unsigned DIV_N      = 2229,
    parameter int unsigned CNT_W      = 13,
    parameter int unsigned STROBE_BIT = 11
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick_o,
    output logic strobe_o
);

    localparam int unsigned SIGN = CNT_W - 1;

    logic [CNT_W-1:0] cnt_w;

    generate
        if (STROBE_BIT >= SIGN) begin : g_bad_tap
            $error("pulse_divider: STROBE_BIT must lie below the sign bit");
        end
    endgenerate

    pdiv_counter #(
        .DIV_N (DIV_N),
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .cnt_o (cnt_w)
    );

    pdiv_outstage u_out (
        .term_i   (cnt_w[SIGN]),
        .tap_i    (cnt_w[STROBE_BIT]),
        .en_i     (en),
        .tick_o   (tick_o),
        .strobe_o (strobe_o)
    );

endmodule

// File: rtl/pulse_divider_chk.sv
module pulse_divider_chk #(
    parameter int unsigned DIV_N = 2229,
    parameter int unsigned CNT_W = 13
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             tick,
    input logic [CNT_W-1:0] cnt
);

    localparam int unsigned      SIGN   = CNT_W - 1;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(DIV_N - 2);

    // Enabled edges since the last tick edge (or since reset).
    int unsigned gap_q;
    logic        seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q  <= 0;
            seen_q <= 1'b0;
        end else if (tick) begin
            gap_q  <= 1;
            seen_q <= 1'b1;
        end else if (en) begin
            gap_q  <= gap_q + 1;
        end
    end

    // R1: the first cycle out of reset holds the start count
    assert_reset_load_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> cnt == RELOAD);

    // R1, R2: tick spacing in enabled edges
    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (rst)
        tick |-> gap_q == (seen_q ? DIV_N : DIV_N - 1));

    assert_tick_single_R3: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    assert_tick_at_minus_one_R3: assert property (@(posedge clk) disable iff (rst)
        tick |-> cnt == '1);

    assert_tick_masked_R4: assert property (@(posedge clk) disable iff (rst)
        !en |-> !tick);

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(cnt));

    assert_step_R6: assert property (@(posedge clk) disable iff (rst)
        (en && !cnt[SIGN]) |=> cnt == CNT_W'($past(cnt) - 1'b1));

    assert_reload_R6: assert property (@(posedge clk) disable iff (rst)
        (en && cnt[SIGN]) |=> cnt == RELOAD);

    assert_no_overrange_R6: assert property (@(posedge clk) disable iff (rst)
        !cnt[SIGN] |-> cnt <= RELOAD);

endmodule

bind pulse_divider pulse_divider_chk #(
    .DIV_N (DIV_N),
    .CNT_W (CNT_W)
) u_chk (
    .clk  (clk),
    .rst  (rst),
    .en   (en),
    .tick (tick_o),
    .cnt  (cnt_w)
);

// File: tb/pulse_divider_tb.sv
module pulse_divider_tb;

    localparam int N  = 2229;
    localparam int W  = 13;
    localparam int SB = 11;
    localparam int STB_FALL = 181;
    localparam int STB_LOW  = 2048;

    // {cycles, enable-on run, enable-off run}
    localparam logic [31:0] STIM [4] = '{
        {16'd5000, 8'd1,   8'd0},
        {16'd3000, 8'd3,   8'd1},
        {16'd2500, 8'd1,   8'd4},
        {16'd4000, 8'd200, 8'd37}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic tick_o;
    logic strobe_o;

    int checks = 0;
    int errors = 0;
    int ev     = 0;     // enabled edges since reset (requirement-level model)
    int terr   = 0;
    int serr   = 0;
    int t_act, t_exp, s_act, s_exp;
    logic last_tick, last_strobe;

    always #10 clk = ~clk;

    pulse_divider u_dut (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .tick_o   (tick_o),
        .strobe_o (strobe_o)
    );

    function automatic logic [W-1:0] mdl_cnt(input int e);
        int m = e % N;
        if (m == N - 1) return '1;
        return W'(N - 2 - m);
    endfunction

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One clock: drive, sample at the falling edge against the model, advance.
    task automatic run_cyc(input logic r, input logic enb);
        logic et;
        logic es;
        rst = r;
        en  = enb;
        @(negedge clk);
        last_tick   = tick_o;
        last_strobe = strobe_o;
        if (!r) begin
            et = enb && ((ev % N) == N - 1);
            es = mdl_cnt(ev)[SB];
            if (last_tick !== et) begin
                if (terr == 0) begin t_act = int'(last_tick); t_exp = int'(et); end
                terr++;
            end
            if (last_strobe !== es) begin
                if (serr == 0) begin s_act = int'(last_strobe); s_exp = int'(es); end
                serr++;
            end
        end
        @(posedge clk);
        if (r) ev = 0;
        else if (enb) ev++;
        #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        int k;
        int p;
        int low_cnt;
        int fall_p;
        logic post_tick;

        // R1: reset state
        repeat (3) run_cyc(1'b1, 1'b1);
        chk(last_tick == 1'b0, "R1", "tick during reset", int'(last_tick), 0);
        chk(last_strobe == mdl_cnt(0)[SB], "R1", "strobe during reset", int'(last_strobe), int'(mdl_cnt(0)[SB]));

        // R1: first tick after release
        k = 0;
        run_cyc(1'b0, 1'b1);
        chk(last_tick == 1'b0, "R1", "tick first cycle after reset", int'(last_tick), 0);
        while (!last_tick && k < 3000) begin
            k++;
            run_cyc(1'b0, 1'b1);
        end
        chk(k == N - 1, "R1", "cycles to first tick", k, N - 1);

        // R2, R3, R5: one full period with enable held high
        p = 0; low_cnt = 0; fall_p = -1; post_tick = 1'b1;
        do begin
            p++;
            run_cyc(1'b0, 1'b1);
            if (p == 1) post_tick = last_tick;
            if (!last_strobe) begin
                low_cnt++;
                if (fall_p < 0) fall_p = p;
            end
        end while (!last_tick && p < 3000);
        chk(post_tick == 1'b0, "R3", "tick width", int'(post_tick), 0);
        chk(p == N, "R2", "tick period", p, N);
        chk(fall_p == STB_FALL, "R5", "strobe fall offset", fall_p, STB_FALL);
        chk(low_cnt == STB_LOW, "R5", "strobe low length", low_cnt, STB_LOW);
        chk(last_strobe == 1'b1, "R5", "strobe high at tick", int'(last_strobe), 1);

        // R4: enable drops exactly in the terminal cycle
        while ((ev % N) != N - 1) run_cyc(1'b0, 1'b1);
        for (int i = 0; i < 3; i++) begin
            run_cyc(1'b0, 1'b0);
            chk(last_tick == 1'b0, "R4", "tick masked while paused", int'(last_tick), 0);
        end
        run_cyc(1'b0, 1'b1);
        chk(last_tick == 1'b1, "R4", "held tick released on resume", int'(last_tick), 1);
        chk(terr == 0, "R2", "directed tick trace", t_act, t_exp);
        chk(serr == 0, "R5", "directed strobe trace", s_act, s_exp);

        // Vector table: enable patterns compared against the model every cycle
        for (int v = 0; v < 4; v++) begin
            int cyc = int'(STIM[v][31:16]);
            int on  = int'(STIM[v][15:8]);
            int off = int'(STIM[v][7:0]);
            terr = 0;
            serr = 0;
            for (int c = 0; c < cyc; c++) begin
                run_cyc(1'b0, (c % (on + off)) < on);
            end
            chk(terr == 0, "R2/R4", $sformatf("vector %0d tick trace", v), t_act, t_exp);
            chk(serr == 0, "R5/R6", $sformatf("vector %0d strobe trace", v), s_act, s_exp);
        end

        // R1: reset in mid-period restarts the timing
        repeat (777) run_cyc(1'b0, 1'b1);
        repeat (2) run_cyc(1'b1, 1'b1);
        chk(last_tick == 1'b0, "R1", "tick during mid-run reset", int'(last_tick), 0);
        terr = 0;
        serr = 0;
        k = 0;
        run_cyc(1'b0, 1'b1);
        while (!last_tick && k < 3000) begin
            k++;
            run_cyc(1'b0, 1'b1);
        end
        chk(k == N - 1, "R1", "first tick after mid-run reset", k, N - 1);
        chk(serr == 0, "R6", "strobe trace after mid-run reset", s_act, s_exp);

        finish_run();
    end

endmodule